// File: doc/BRIEF.md
# Acquisition Stream Source Selector

This block sits between the sample inputs of an acquisition chain and a DMA engine. On every clock it may take one sample and forward one 32-bit word, with a valid flag, to the DMA stream. The word comes from one of four places: the live ADC word, an internal running count, the word currently driven to the DAC, or a fixed marker pattern. The three non-ADC sources let software check the capture path without an analog signal. They can confirm that no words are dropped, that the transmit path loops back correctly, and that the bus carries a recognisable constant.

Sample timing always comes from the ADC valid strobe, so the stream rate is the same in every mode. An external acquisition-window signal can gate that strobe. A gate-override bit in the control word removes the gate, and then every strobe produces an output word. The output is registered, so each word appears one clock after its sample. The control word is read in the same cycle as each sample, so a change of source applies from the next sample on.

Top module: `acq_stream_select`

## Requirements
- R1: With control bits [5:4] = 2'b00, each emitted word equals the `adc_data` value present in the sample cycle.
- R2: With control bits [5:4] = 2'b01, the emitted word is the test count, zero-extended. The count is 0 after reset and rises by one after each word emitted in this mode. It wraps modulo 2^CNT_W, and CNT_W defaults to 32.
- R3: With control bits [5:4] = 2'b10, each emitted word equals the `dac_data` value present in the sample cycle.
- R4: With control bits [5:4] = 2'b11, each emitted word equals CONST_WORD, which defaults to 32'hDEADBEEF.
- R5: `out_valid` is high in a cycle only if `adc_valid` was high in the cycle before. This holds in all four modes.
- R6: Control bit 3 = 0 turns the gate on: a sample is emitted only if `acq_gate` is also high in its cycle. Control bit 3 = 1 turns the gate off: `acq_gate` has no effect and every `adc_valid` strobe is emitted.
- R7: Each sample leaves one clock after its cycle. While `out_valid` is low, `out_data` keeps its last value.
- R8: The source used for a sample is the one selected by the control word in that sample's cycle. A change takes effect on the very next sample.
- R9: While `rst_n` is low, `out_valid` is 0, `out_data` is 0 and the test count is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| adc_data | input | DATA_W | Live ADC sample word |
| adc_valid | input | 1 | Sample strobe |
| dac_data | input | DATA_W | Word currently sent to the DAC |
| acq_gate | input | 1 | Acquisition window, high = open |
| ctrl_reg | input | CTRL_W | Control word: [5:4] source code, [3] gate override |
| out_data | output | DATA_W | Word toward DMA |
| out_valid | output | 1 | Word valid toward DMA |

## Verification
Several rules are checked by assertions on every cycle. These are the gating rules, the marker and loopback values, the holding of data between samples, the count staying still when no count word is emitted, and the reset values. Other behaviour can only be shown by the bench's scenarios: the exact sequence of count values, wrap-around at the counter width, source changes between back-to-back samples, and the count restarting after a mid-run reset. A reference model in the bench is compared with the outputs on every clock for these cases.

// File: rtl/acq_sel_pkg.sv
package acq_sel_pkg;
  typedef enum logic [1:0] {
    SRC_ADC   = 2'b00,
    SRC_COUNT = 2'b01,
    SRC_DAC   = 2'b10,
    SRC_CONST = 2'b11
  } src_e;

  localparam int SEL_LSB      = 4;
  localparam int GATE_OFF_BIT = 3;

  function automatic src_e decode_src(input logic [1:0] code);
    return src_e'(code);
  endfunction

  function automatic logic gate_pass(input logic strobe, input logic gate_off,
                                     input logic window);
    return strobe & (gate_off | window);
  endfunction
endpackage

// File: rtl/acq_gate.sv
module acq_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic adc_valid,
  input  logic gate_off,
  input  logic window,
  output logic pass
);
  import acq_sel_pkg::*;

  assign pass = gate_pass(adc_valid, gate_off, window);

  // R6: with the gate on and the window closed, nothing passes
  a_r6_window_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (!gate_off && !window) |-> !pass);
  // R5: nothing passes without a strobe
  a_r5_need_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    pass |-> adc_valid);
endmodule

// File: rtl/acq_test_counter.sv
module acq_test_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  output logic [CNT_W-1:0] count
);
  always_ff @(posedge clk) begin
    if (!rst_n) count <= '0;
    else if (step) count <= count + 1'b1;
  end

  // R2: the count moves only on an emitted count sample
  a_r2_count_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(step) |-> $stable(count));
  // R9: reset clears the count
  a_r9_count_cleared: assert property (@(posedge clk)
    !rst_n |=> (count == '0));
endmodule

// File: rtl/acq_src_mux.sv
module acq_src_mux #(
  parameter int          DATA_W     = 32,
  parameter int          CNT_W      = 32,
  parameter logic [31:0] CONST_WORD = 32'hDEADBEEF
) (
  input  acq_sel_pkg::src_e  sel,
  input  logic [DATA_W-1:0]  adc_data,
  input  logic [DATA_W-1:0]  dac_data,
  input  logic [CNT_W-1:0]   count,
  output logic [DATA_W-1:0]  word
);
  import acq_sel_pkg::*;

  localparam logic [DATA_W-1:0] MARKER = DATA_W'(CONST_WORD);

  always_comb begin
    unique case (sel)
      SRC_ADC:   word = adc_data;
      SRC_COUNT: word = DATA_W'(count);
      SRC_DAC:   word = dac_data;
      default:   word = MARKER;
    endcase
  end
endmodule

// File: rtl/acq_stream_select.sv
module acq_stream_select #(
  parameter int          DATA_W     = 32,
  parameter int          CNT_W      = 32,
  parameter int          CTRL_W     = 8,
  parameter logic [31:0] CONST_WORD = 32'hDEADBEEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] adc_data,
  input  logic              adc_valid,
  input  logic [DATA_W-1:0] dac_data,
  input  logic              acq_gate,
  input  logic [CTRL_W-1:0] ctrl_reg,
  output logic [DATA_W-1:0] out_data,
  output logic              out_valid
);
  import acq_sel_pkg::*;

  localparam logic [DATA_W-1:0] MARKER = DATA_W'(CONST_WORD);

  src_e              sel;
  logic              gate_off;
  logic              pass;
  logic              count_step;
  logic [CNT_W-1:0]  count;
  logic [DATA_W-1:0] picked;

  assign sel        = decode_src(ctrl_reg[SEL_LSB+1:SEL_LSB]);
  assign gate_off   = ctrl_reg[GATE_OFF_BIT];
  assign count_step = pass && (sel == SRC_COUNT);

  acq_gate u_gate (
    .clk(clk), .rst_n(rst_n), .adc_valid(adc_valid),
    .gate_off(gate_off), .window(acq_gate), .pass(pass)
  );

  acq_test_counter #(.CNT_W(CNT_W)) u_count (
    .clk(clk), .rst_n(rst_n), .step(count_step), .count(count)
  );

  acq_src_mux #(.DATA_W(DATA_W), .CNT_W(CNT_W), .CONST_WORD(CONST_WORD)) u_mux (
    .sel(sel), .adc_data(adc_data), .dac_data(dac_data),
    .count(count), .word(picked)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= pass;
      if (pass) out_data <= picked;
    end
  end

  // R5: every output word traces back to a strobe one cycle earlier
  a_r5_valid_from_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(adc_valid));
  // R6: gate on and window closed gives no word
  a_r6_gate_respected: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!ctrl_reg[GATE_OFF_BIT] && !acq_gate) |-> !out_valid);
  // R4: marker mode yields the fixed pattern
  a_r4_marker: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(sel == SRC_CONST)) |-> (out_data == MARKER));
  // R3: loopback mode yields the DAC word of the sample cycle
  a_r3_loopback: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(sel == SRC_DAC)) |-> (out_data == $past(dac_data)));
  // R1: ADC mode yields the ADC word of the sample cycle
  a_r1_adc_path: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(sel == SRC_ADC)) |-> (out_data == $past(adc_data)));
  // R7: data holds while no word is emitted
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> $stable(out_data));
  // R9: reset forces the output idle
  a_r9_reset_idle: assert property (@(posedge clk)
    !rst_n |=> (!out_valid && out_data == '0));
endmodule

// File: tb/acq_stream_select_bench.sv
module acq_stream_select_bench;
  localparam int DATA_W = 32;
  localparam int CNT_W  = 4;
  localparam int CTRL_W = 8;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [DATA_W-1:0] adc_data = '0;
  logic              adc_valid = 1'b0;
  logic [DATA_W-1:0] dac_data = '0;
  logic              acq_gate = 1'b0;
  logic [CTRL_W-1:0] ctrl_reg = '0;
  logic [DATA_W-1:0] out_data;
  logic              out_valid;

  int checks = 0;
  int errors = 0;

  // model state
  int unsigned       m_cnt = 0;
  logic              m_valid = 1'b0;
  logic [DATA_W-1:0] m_data = '0;
  logic [1:0]        m_src = 2'b00;
  logic              compare_on = 1'b0;

  always #10 clk = ~clk;

  acq_stream_select #(.DATA_W(DATA_W), .CNT_W(CNT_W), .CTRL_W(CTRL_W))
    u_acq_stream_select (
      .clk(clk), .rst_n(rst_n), .adc_data(adc_data), .adc_valid(adc_valid),
      .dac_data(dac_data), .acq_gate(acq_gate), .ctrl_reg(ctrl_reg),
      .out_data(out_data), .out_valid(out_valid));

  // behavioural reference
  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt   <= 0;
      m_valid <= 1'b0;
      m_data  <= '0;
    end else begin
      bit take;
      take = adc_valid && (ctrl_reg[3] || acq_gate);
      m_valid <= take;
      m_src   <= ctrl_reg[5:4];
      if (take) begin
        case (ctrl_reg[5:4])
          2'b00: m_data <= adc_data;
          2'b01: begin
            m_data <= DATA_W'(m_cnt);
            m_cnt  <= (m_cnt + 1) % (1 << CNT_W);
          end
          2'b10: m_data <= dac_data;
          default: m_data <= 32'hDEADBEEF;
        endcase
      end
    end
  end

  function automatic string tag_for(input logic [1:0] s);
    case (s)
      2'b00: return "R1";
      2'b01: return "R2";
      2'b10: return "R3";
      default: return "R4";
    endcase
  endfunction

  always @(negedge clk) begin
    if (compare_on) begin
      checks++;
      if (out_valid !== m_valid) begin
        errors++;
        $display("FAIL R5/R6 valid: actual %0b expected %0b at %0t", out_valid, m_valid, $time);
      end
      checks++;
      if (out_data !== m_data) begin
        errors++;
        $display("FAIL %s/R7/R8 data: actual %h expected %h at %0t",
                 tag_for(m_src), out_data, m_data, $time);
      end
    end
  end

  task automatic check_idle(input string what);
    checks++;
    if (out_valid !== 1'b0 || out_data !== '0) begin
      errors++;
      $display("FAIL R9 %s: actual valid %0b data %h expected 0 0", what, out_valid, out_data);
    end
  endtask

  task automatic run(input int n, input logic [1:0] src, input logic gate_off,
                     input int valid_pct, input int gate_pct);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      ctrl_reg  = {2'b00, src, gate_off, 3'b000};
      adc_data  = $urandom;
      dac_data  = $urandom;
      adc_valid = ($urandom % 100) < valid_pct;
      acq_gate  = ($urandom % 100) < gate_pct;
    end
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check_idle("reset state");
    rst_n = 1'b1;
    compare_on = 1'b1;
    // R1 ADC path, gate off, sparse and dense strobes
    run(40, 2'b00, 1'b1, 60, 0);
    run(40, 2'b00, 1'b1, 100, 0);
    // R6 gate on with toggling window
    run(60, 2'b00, 1'b0, 80, 50);
    // R6 gate on, window closed: nothing passes
    run(20, 2'b00, 1'b0, 100, 0);
    // R2 count mode through a wrap at 2^CNT_W
    run(50, 2'b01, 1'b1, 100, 0);
    run(40, 2'b01, 1'b0, 70, 60);
    // R3 loopback, R4 marker
    run(40, 2'b10, 1'b1, 70, 0);
    run(40, 2'b11, 1'b0, 80, 70);
    // R8 source changes between back-to-back samples
    for (int k = 0; k < 80; k++) run(1, 2'(k % 4), 1'b1, 100, 0);
    for (int k = 0; k < 80; k++) run(1, 2'($urandom), 1'($urandom), 75, 50);
    // R9 mid-run reset, then count restarts at zero
    @(negedge clk);
    rst_n = 1'b0;
    compare_on = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check_idle("mid-run reset");
    rst_n = 1'b1;
    compare_on = 1'b1;
    run(30, 2'b01, 1'b1, 100, 0);
    @(negedge clk);
    adc_valid = 1'b0;
    repeat (3) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule